// File: doc/BRIEF.md
# Packet-command I2C master

This block is an I2C bus master driven by one command word per byte-level packet. A packet may open with a START condition followed by a 7-bit target address and its direction bit, may carry one data byte out to the target or in from it, and may close with a STOP condition. Software loads the outgoing byte into a buffer register, writes a command word, waits for the packet-done status bit and then reads the NAK result and any received byte. It clears status bits by writing ones to them.

The two lines are open drain. An output of 1 on `scl_oe` or `sda_oe` pulls the line low, and an output of 0 releases it. The `scl_in` and `sda_in` inputs return the line levels. Bit timing comes from `tick`, a one-cycle strobe from a separate timing block. Each bus bit takes four ticks: drive the data, release SCL, sample, pull SCL low. A packet without STOP leaves SCL held low, so the next packet can continue the same transfer with or without a new START.

Top module: `i2c_pkt_master`

## Requirements
- R1: After reset both line enables are 0, the status register reads 0, the byte fields of the buffer read 0 and bus-busy (buffer bit 16) is 0.
- R2: Register writes are selected by `wr_sel`: 0 is the command, 1 is the buffer (bits [7:0] hold the transmit byte) and 2 is the status register. A command write without packet enable (bit 16) causes no bus activity and sets no status bit.
- R3: A command with START (bit 0) sends a START and then the address byte. Its upper seven bits are command bits [30:24] and its last bit is the direction: 1 when RX (bit 3) is set, 0 otherwise.
- R4: A command with TX (bit 1) and without RX sends the buffer's transmit byte MSB first. An acknowledged address or transmitted byte sets TX-ACK (status bit 0).
- R5: A command with RX (bit 3) receives one byte into buffer bits [15:8] and sets RX-done (status bit 2). The master answers the byte with ACK, or with NAK when RX-last (bit 4) is set.
- R6: A NAK on the address byte sets TX-NAK (status bit 1) and skips the data byte. A STOP requested by bit 5 is still sent.
- R7: Packet-done (status bit 16) is set at the end of every accepted packet, including a packet made of only START and address.
- R8: A STOP (bit 5) sets normal-stop (status bit 4), clears bus-busy and leaves both lines released.
- R9: After a packet without STOP, SCL stays low and bus-busy stays 1. A following packet without START continues the transfer with no new address byte.
- R10: Writing 1 to a status bit clears it. When the engine sets a bit in the same cycle as a write clears it, the bit ends up set.
- R11: Buffer bits 17 and 18 show the current SDA and SCL line levels.
- R12: A command written while a packet is in progress is ignored.
- R13: Status bits 3 and 5 are never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Quarter-bit timing strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 buffer, 2 status |
| wr_data | input | 32 | Write data |
| xfer_buf | output | 32 | Buffer view: tx byte [7:0], rx byte [15:8], busy [16], SDA [17], SCL [18] |
| irq_sts | output | 32 | Status register |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The engine can set packet-done in the same cycle that software writes a 1 to that bit to clear it. To force this, the bench writes all ones to the status register on every cycle while a write packet runs. It stops writing on the first cycle in which packet-done reads back as 1. A correct design must show the done bit at that point, and all the other bits must read 0 because the repeated writes have cleared them. If the clear won the collision, the done bit would never appear and the wait would end in a reported failure.

// File: rtl/i2c_pkt_master.sv
module i2c_pkt_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] xfer_buf,
  output logic [31:0] irq_sts,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_BYTE, S_STOP, S_DONE} st_t;
  st_t st;
  logic [1:0]  ph;
  logic [3:0]  bcnt;
  logic [7:0]  sh, tx_byte, rx_byte;
  logic [10:0] cmd_q;
  logic [16:0] evt;
  logic        busy, is_addr, ackbit;

  logic [6:0] f_addr;
  logic f_stop, f_last, f_rx, f_tx, run, cmd_wr, rxing;
  assign {f_addr, f_stop, f_last, f_rx, f_tx} = cmd_q;
  assign run    = (st != S_IDLE);
  assign cmd_wr = wr_en && (wr_sel == 2'd0) && wr_data[16] && !run;
  assign rxing  = !is_addr && f_rx;
  assign xfer_buf = {13'd0, scl_in, sda_in, busy, rx_byte, tx_byte};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_byte <= '0;
    else if (wr_en && wr_sel == 2'd1) tx_byte <= wr_data[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_sts <= '0;
    else irq_sts <= (irq_sts & ~((wr_en && wr_sel == 2'd2) ? wr_data : 32'd0)) | {15'd0, evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bcnt <= '0; sh <= '0; rx_byte <= '0;
      cmd_q <= '0; evt <= '0; busy <= 1'b0; is_addr <= 1'b0; ackbit <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      evt <= '0;
      case (st)
        S_IDLE: if (cmd_wr) begin
          cmd_q <= {wr_data[30:24], wr_data[5], wr_data[4], wr_data[3], wr_data[1]};
          ph <= '0;
          bcnt <= '0;
          if (wr_data[0]) st <= S_START;
          else if (wr_data[3] || wr_data[1]) begin
            st <= S_BYTE;
            is_addr <= 1'b0;
            sh <= wr_data[3] ? 8'h00 : tx_byte;
          end else if (wr_data[5] && busy) st <= S_STOP;
          else st <= S_DONE;
        end
        S_START: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: begin sda_oe <= 1'b1; busy <= 1'b1; end
            2'd3: begin
              scl_oe <= 1'b1;
              st <= S_BYTE;
              is_addr <= 1'b1;
              sh <= {f_addr, f_rx};
              bcnt <= '0;
            end
          endcase
        end
        S_BYTE: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: if (bcnt == 4'd8) sda_oe <= rxing && !f_last;
                  else sda_oe <= rxing ? 1'b0 : !sh[7];
            2'd1: scl_oe <= 1'b0;
            2'd2: if (bcnt == 4'd8) ackbit <= sda_in;
                  else sh <= {sh[6:0], sda_in};
            2'd3: begin
              scl_oe <= 1'b1;
              if (bcnt != 4'd8) bcnt <= bcnt + 4'd1;
              else begin
                bcnt <= '0;
                if (rxing) begin
                  rx_byte <= sh;
                  evt[2] <= 1'b1;
                  st <= f_stop ? S_STOP : S_DONE;
                end else if (ackbit) begin
                  evt[1] <= 1'b1;
                  st <= f_stop ? S_STOP : S_DONE;
                end else begin
                  evt[0] <= 1'b1;
                  if (is_addr && (f_rx || f_tx)) begin
                    is_addr <= 1'b0;
                    sh <= f_rx ? 8'h00 : tx_byte;
                  end else st <= f_stop ? S_STOP : S_DONE;
                end
              end
            end
          endcase
        end
        S_STOP: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: begin sda_oe <= 1'b0; busy <= 1'b0; evt[4] <= 1'b1; end
            2'd3: st <= S_DONE;
          endcase
        end
        S_DONE: begin
          evt[16] <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module i2c_pkt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic        wr_en_bit,
  input logic        run,
  input logic        done_evt,
  input logic        done_sts,
  input logic        bus_busy,
  input logic        scl_oe,
  input logic [10:0] cmd_q
);
  // R2
  no_enable_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && wr_en && wr_sel == 2'd0 && !wr_en_bit |=> !run);
  // R12
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && wr_en && wr_sel == 2'd0 |=> $stable(cmd_q));
  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done_sts);
  // R10
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd2 && !done_evt && done_sts |=> !done_sts);
  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> !scl_oe);
  // R9
  hold_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy && !run |-> scl_oe);
endmodule

bind i2c_pkt_master i2c_pkt_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_en_bit(wr_data[16]), .run(run), .done_evt(evt[16]),
  .done_sts(irq_sts[16]), .bus_busy(busy), .scl_oe(scl_oe), .cmd_q(cmd_q)
);

// File: tb/i2c_pkt_master_tb.sv
module i2c_pkt_master_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] xfer_buf, irq_sts;
  logic scl_oe, sda_oe;
  int n_chk = 0, n_fail = 0;

  localparam logic [6:0] SLV = 7'h50;
  localparam logic [6:0] BAD = 7'h22;
  localparam int EN = 1 << 16, ST = 1, TX = 2, RX = 8, LAST = 16, SP = 32;

  always #10 clk = ~clk;

  logic [1:0] tdiv = 0;
  always @(posedge clk) begin tdiv <= tdiv + 2'd1; tick <= (tdiv == 2'd3); end

  logic s_drv;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || s_drv);

  i2c_pkt_master dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .xfer_buf(xfer_buf), .irq_sts(irq_sts),
    .scl_in(scl_w), .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe));

  // target model
  logic ps, pd, s_rdm, s_mnak;
  logic [1:0] s_st;
  logic [3:0] s_cnt;
  logic [7:0] s_sr, s_got;
  int s_nwr;
  logic [7:0] s_rdata = 8'h96;
  always @(posedge clk) begin
    if (!rst_n) begin
      ps <= 1; pd <= 1; s_st <= 0; s_cnt <= 0; s_drv <= 0; s_sr <= 0;
      s_got <= 0; s_nwr <= 0; s_rdm <= 0; s_mnak <= 0;
    end else begin
      ps <= scl_w; pd <= sda_w;
      if (ps && scl_w && pd && !sda_w) begin s_st <= 1; s_cnt <= 0; s_drv <= 0; end
      else if (ps && scl_w && !pd && sda_w) begin s_st <= 0; s_drv <= 0; end
      else if (!ps && scl_w && s_st != 0) begin
        if (s_cnt < 8 && s_st != 3) s_sr <= {s_sr[6:0], sda_w};
        if (s_cnt == 8 && s_st == 3) s_mnak <= sda_w;
        s_cnt <= s_cnt + 1;
      end else if (ps && !scl_w && s_st != 0) begin
        if (s_cnt == 8) begin
          if (s_st == 1) begin
            if (s_sr[7:1] == SLV) begin s_drv <= 1; s_rdm <= s_sr[0]; end
            else s_st <= 0;
          end else if (s_st == 2) begin s_drv <= 1; s_got <= s_sr; s_nwr <= s_nwr + 1; end
          else s_drv <= 0;
        end else if (s_cnt == 9) begin
          s_cnt <= 0;
          if (s_st == 1) begin s_st <= s_rdm ? 2'd3 : 2'd2; s_drv <= s_rdm && !s_rdata[7]; end
          else if (s_st == 2) s_drv <= 0;
          else if (s_mnak) begin s_st <= 0; s_drv <= 0; end
          else s_drv <= !s_rdata[7];
        end else if (s_st == 3) s_drv <= !s_rdata[3'(7 - s_cnt)];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic [31:0] cmd(input logic [6:0] a, input int f);
    return 32'(f) | ({25'd0, a} << 24);
  endfunction

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 4000 && !seen; i++) begin @(negedge clk); if (irq_sts[16]) seen = 1; end
    chk(seen, {tag, " packet done"}, irq_sts, 32'h10000);
  endtask

  task automatic t_reset();
    chk(irq_sts == 0, "R1 status", irq_sts, 0);
    chk(xfer_buf[16:0] == 0 && !scl_oe && !sda_oe, "R1 buffer/lines", {scl_oe, sda_oe, xfer_buf[29:0]}, 0);
    chk(xfer_buf[18:17] == 2'b11, "R11 lines high", 32'(xfer_buf[18:17]), 3);
  endtask

  task automatic t_no_enable();
    wr(0, cmd(SLV, ST | TX | SP));
    repeat (200) @(negedge clk);
    chk(irq_sts == 0 && !xfer_buf[16] && !scl_oe, "R2 no enable", irq_sts, 0);
  endtask

  task automatic t_write();
    int n0 = s_nwr;
    wr(1, 32'hA5);
    wr(0, cmd(SLV, EN | ST | TX | SP));
    wait_done("R4");
    chk(irq_sts == 32'h10011, "R4 R7 R8 R13 status", irq_sts, 32'h10011);
    chk(s_nwr == n0 + 1 && s_got == 8'hA5 && !s_rdm, "R3 R4 byte at target", {24'd0, s_got}, 32'hA5);
    chk(!xfer_buf[16] && !scl_oe && !sda_oe, "R8 released", xfer_buf, 0);
    wr(2, 32'hFFFF_FFFF);
    chk(irq_sts == 0, "R10 w1c", irq_sts, 0);
  endtask

  task automatic t_read();
    wr(0, cmd(SLV, EN | ST | RX | LAST | SP));
    wait_done("R5");
    chk(xfer_buf[15:8] == 8'h96, "R5 rx byte", 32'(xfer_buf[15:8]), 32'h96);
    chk(irq_sts == 32'h10015, "R5 status", irq_sts, 32'h10015);
    chk(s_rdm && s_mnak, "R3 R5 rw bit and NAK", {30'd0, s_rdm, s_mnak}, 3);
    wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_nak();
    int n0 = s_nwr;
    wr(1, 32'h77);
    wr(0, cmd(BAD, EN | ST | TX | SP));
    wait_done("R6");
    chk(irq_sts == 32'h10012, "R6 status", irq_sts, 32'h10012);
    chk(s_nwr == n0, "R6 data skipped", 32'(s_nwr), 32'(n0));
    chk(!xfer_buf[16] && !scl_oe, "R6 stop sent", xfer_buf, 0);
    wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_hold();
    int n0 = s_nwr;
    wr(0, cmd(SLV, EN | ST));
    wait_done("R7");
    chk(irq_sts == 32'h10001, "R7 start-only", irq_sts, 32'h10001);
    repeat (100) @(negedge clk);
    chk(xfer_buf[16] && scl_oe, "R9 scl held", xfer_buf, 32'h10000);
    chk(xfer_buf[18] == 0, "R11 scl low seen", xfer_buf, 0);
    wr(2, 32'hFFFF_FFFF);
    wr(1, 32'h5A);
    wr(0, cmd(SLV, EN | TX));
    wait_done("R9");
    chk(irq_sts == 32'h10001 && s_got == 8'h5A && s_nwr == n0 + 1, "R9 continue", {24'd0, s_got}, 32'h5A);
    wr(2, 32'hFFFF_FFFF);
    wr(0, cmd(SLV, EN | SP));
    wait_done("R8");
    chk(irq_sts == 32'h10010 && !xfer_buf[16], "R8 stop only", irq_sts, 32'h10010);
    wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_read_ack();
    wr(0, cmd(SLV, EN | ST | RX));
    wait_done("R5");
    chk(!s_mnak && irq_sts == 32'h10005, "R5 ack sent", irq_sts, 32'h10005);
    wr(2, 32'hFFFF_FFFF);
    wr(0, cmd(SLV, EN | RX | LAST | SP));
    wait_done("R5");
    chk(s_mnak && xfer_buf[15:8] == 8'h96 && irq_sts == 32'h10014, "R5 second byte", irq_sts, 32'h10014);
    wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_ignore();
    wr(1, 32'h11);
    wr(0, cmd(SLV, EN | ST | TX | SP));
    repeat (20) @(negedge clk);
    wr(0, cmd(BAD, EN | ST | TX | SP));
    wait_done("R12");
    repeat (600) @(negedge clk);
    chk(irq_sts == 32'h10011 && s_got == 8'h11, "R12 second command ignored", irq_sts, 32'h10011);
    wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_wins();
    bit seen = 0;
    wr(1, 32'h3C);
    wr(0, cmd(SLV, EN | ST | TX | SP));
    @(negedge clk); wr_en = 1; wr_sel = 2; wr_data = 32'hFFFF_FFFF;
    for (int i = 0; i < 4000 && !seen; i++) begin @(negedge clk); if (irq_sts[16]) seen = 1; end
    wr_en = 0;
    chk(seen && irq_sts == 32'h10000, "R10 set beats clear", irq_sts, 32'h10000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_enable();
    t_write();
    t_read();
    t_nak();
    t_hold();
    t_read_ack();
    t_ignore();
    t_set_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule